// File: doc/BRIEF.md
# SAR converter conversion and serial readout sequencer

This block runs an 18-bit successive-approximation converter from the host side. The converter is wired so that one strobe line does two jobs: it starts a conversion and it acts as the chip select. The data-input pin of the converter is tied high. On a start request, or continuously while free-run is enabled, the sequencer raises the strobe. It keeps the strobe high for a programmed number of cycles that covers the worst-case conversion time, so the converter never signals busy. It then lowers the strobe and generates a serial clock from a programmable divider to read the result.

The converter already drives its most significant bit when the strobe falls, and it moves to the next bit on each falling serial-clock edge. The sequencer therefore samples the data line in the last system cycle before every falling edge. Eighteen such samples make one word. The word is presented on a parallel output together with a one-cycle valid pulse. A minimum spacing between successive strobe rises sets the sample rate. A request that arrives while a cycle is running is remembered and served at the first permitted start.

Top module: `sar_readout_ctrl`

## Requirements
- R1: While reset is asserted, and on the cycle after it is released, `cnv`, `sck` and `resultValid` are 0. A conversion cut short by reset delivers no result.
- R2: A new cycle starts only when `startReq` is 1 or a request is pending, or while `freeRun` is 1. With neither input active, `cnv` stays low.
- R3: Each `cnv` high phase lasts exactly `CONV_CYCLES` system clocks.
- R4: `sck` is 0 whenever `cnv` is 1. Each conversion produces exactly `DATA_W` falling `sck` edges, and each `sck` high phase lasts `SCK_DIV` system clocks.
- R5: `result` carries the converter word MSB first: bit `DATA_W-1` is the level of `sdo` before the first falling `sck` edge, and each later bit is the level before the next falling edge.
- R6: `resultValid` is a single-cycle pulse. It occurs once per completed conversion, while `cnv` is low, after the last falling `sck` edge.
- R7: Two rising edges of `cnv` are never closer than the effective period. The effective period is the larger of `PERIOD_CYCLES` and `CONV_CYCLES + 2*SCK_DIV*DATA_W + 3`.
- R8: A `startReq` pulse that arrives while a cycle is running is held and started at the first permitted boundary. Several such pulses during one cycle give one extra conversion.
- R9: While `freeRun` stays 1, successive `cnv` rises are spaced by exactly the effective period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Single-cycle request for one conversion |
| freeRun | input | 1 | Keep converting at the effective period while high |
| cnv | output | 1 | Conversion start strobe and chip select to the converter |
| sck | output | 1 | Serial read clock, idles low |
| sdo | input | 1 | Serial data from the converter |
| result | output | DATA_W | Last assembled conversion word |
| resultValid | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The properties assume that `startReq` and `freeRun` are synchronous to `clk`. They also assume that `sdo` changes only after a falling `sck` edge or a falling `cnv` edge, and holds steady across the sampling cycle. The bench keeps within this. A converter model updates `sdo` on the falling half of the system clock, and only once it has seen the strobe or the serial clock fall. Requests come at random gaps, some of them inside a running cycle. The directed cases cover a long idle stretch, a burst of pulses during one cycle, free-run and a reset during a conversion. Each conversion word is drawn at random.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // Strobes from the sequencer to the capture datapath.
  typedef struct packed {
    logic clear;    // new cycle launched, empty the shift register
    logic shift;    // sample sdo into the LSB end
    logic publish;  // move the assembled word to the output
  } seqStrobe_t;

  // Smallest spacing between strobe rises that still fits conversion,
  // readout and the publish step.
  function automatic int unsigned effPeriod(input int unsigned period,
                                            input int unsigned conv,
                                            input int unsigned div,
                                            input int unsigned width);
    int unsigned need;
    need = conv + 2 * div * width + 3;
    return (period > need) ? period : need;
  endfunction

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned DATA_W        = 18,
  parameter int unsigned CONV_CYCLES   = 160,
  parameter int unsigned SCK_DIV       = 2,
  parameter int unsigned PERIOD_CYCLES = 250
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       freeRun,
  output logic       cnv,
  output logic       sck,
  output seqStrobe_t strobe
);

  localparam int unsigned PERIOD_EFF = effPeriod(PERIOD_CYCLES, CONV_CYCLES, SCK_DIV, DATA_W);
  localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam int HW = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int PW = $clog2(PERIOD_EFF);
  localparam logic [CW-1:0] CONV_LAST   = CW'(CONV_CYCLES - 1);
  localparam logic [HW-1:0] HALF_LAST   = HW'(SCK_DIV - 1);
  localparam logic [BW-1:0] BIT_LAST    = BW'(DATA_W - 1);
  localparam logic [PW-1:0] PERIOD_LAST = PW'(PERIOD_EFF - 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_READ
  } seqState_t;

  seqState_t       state;
  logic [CW-1:0]   convCnt;
  logic [HW-1:0]   halfCnt;
  logic [BW-1:0]   bitCnt;
  logic [PW-1:0]   periodCnt;
  logic            cnvQ;
  logic            sckQ;
  logic            pending;
  logic            publishQ;
  logic            launch;
  logic            lastHalf;
  logic            periodOpen;

  assign periodOpen = (periodCnt == PERIOD_LAST);
  assign lastHalf   = (halfCnt == HALF_LAST);
  assign launch     = (state == ST_IDLE) && periodOpen && (startReq || pending || freeRun);

  always_comb begin
    strobe.clear   = launch;
    strobe.shift   = (state == ST_READ) && sckQ && lastHalf;
    strobe.publish = publishQ;
  end

  assign cnv = cnvQ;
  assign sck = sckQ;

  // Request capture: a pulse that cannot start now waits for the boundary.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (launch) begin
      pending <= 1'b0;
    end else if (startReq) begin
      pending <= 1'b1;
    end
  end

  // Spacing counter since the last strobe rise, saturating at the period.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt <= PERIOD_LAST;
    end else if (launch) begin
      periodCnt <= '0;
    end else if (!periodOpen) begin
      periodCnt <= periodCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnvQ     <= 1'b0;
      sckQ     <= 1'b0;
      convCnt  <= '0;
      halfCnt  <= '0;
      bitCnt   <= '0;
      publishQ <= 1'b0;
    end else begin
      publishQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (launch) begin
            cnvQ    <= 1'b1;
            convCnt <= '0;
            state   <= ST_CONV;
          end
        end
        ST_CONV: begin
          if (convCnt == CONV_LAST) begin
            cnvQ    <= 1'b0;
            sckQ    <= 1'b0;
            halfCnt <= '0;
            bitCnt  <= '0;
            state   <= ST_READ;
          end else begin
            convCnt <= convCnt + 1'b1;
          end
        end
        ST_READ: begin
          if (lastHalf) begin
            halfCnt <= '0;
            sckQ    <= ~sckQ;
            if (sckQ) begin
              if (bitCnt == BIT_LAST) begin
                publishQ <= 1'b1;
                state    <= ST_IDLE;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sar_shift_dp.sv
module sar_shift_dp
  import sar_pkg::*;
#(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              sdo,
  output logic [DATA_W-1:0] result,
  output logic              resultValid
);

  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.clear) begin
      shiftReg <= '0;
    end else if (strobe.shift) begin
      shiftReg <= {shiftReg[DATA_W-2:0], sdo};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strobe.publish;
      if (strobe.publish) begin
        result <= shiftReg;
      end
    end
  end

endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned DATA_W        = 18,
  parameter int unsigned CONV_CYCLES   = 160,
  parameter int unsigned SCK_DIV       = 2,
  parameter int unsigned PERIOD_CYCLES = 250
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              freeRun,
  output logic              cnv,
  output logic              sck,
  input  logic              sdo,
  output logic [DATA_W-1:0] result,
  output logic              resultValid
);

  seqStrobe_t seqStrobe;

  sar_seq_ctrl #(
    .DATA_W       (DATA_W),
    .CONV_CYCLES  (CONV_CYCLES),
    .SCK_DIV      (SCK_DIV),
    .PERIOD_CYCLES(PERIOD_CYCLES)
  ) i_seq (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .freeRun (freeRun),
    .cnv     (cnv),
    .sck     (sck),
    .strobe  (seqStrobe)
  );

  sar_shift_dp #(
    .DATA_W(DATA_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (seqStrobe),
    .sdo        (sdo),
    .result     (result),
    .resultValid(resultValid)
  );

endmodule

// File: rtl/sar_readout_checker.sv
module sar_readout_checker
  import sar_pkg::*;
#(
  parameter int unsigned DATA_W        = 18,
  parameter int unsigned CONV_CYCLES   = 160,
  parameter int unsigned SCK_DIV       = 2,
  parameter int unsigned PERIOD_CYCLES = 250
) (
  input logic clk,
  input logic rstN,
  input logic cnv,
  input logic sck,
  input logic resultValid
);

  localparam int unsigned PERIOD_EFF = effPeriod(PERIOD_CYCLES, CONV_CYCLES, SCK_DIV, DATA_W);

  int unsigned highLen;
  int unsigned sinceRise;
  int unsigned fallCnt;
  logic        cnvQ;
  logic        sckQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highLen   <= 0;
      sinceRise <= PERIOD_EFF;
      fallCnt   <= 0;
      cnvQ      <= 1'b0;
      sckQ      <= 1'b0;
    end else begin
      cnvQ    <= cnv;
      sckQ    <= sck;
      highLen <= cnv ? highLen + 1 : 0;
      if (cnv && !cnvQ) begin
        sinceRise <= 1;
      end else if (sinceRise < PERIOD_EFF) begin
        sinceRise <= sinceRise + 1;
      end
      if (cnv && !cnvQ) begin
        fallCnt <= 0;
      end else if (!sck && sckQ) begin
        fallCnt <= fallCnt + 1;
      end
    end
  end

  assert_conv_len_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!cnv && cnvQ) |-> (highLen == CONV_CYCLES));

  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    cnv |-> !sck);

  assert_fall_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (fallCnt == DATA_W));

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  assert_valid_cnv_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> !cnv);

  assert_spacing_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cnv && !cnvQ) |-> (sinceRise >= PERIOD_EFF));

endmodule

bind sar_readout_ctrl sar_readout_checker #(
  .DATA_W       (DATA_W),
  .CONV_CYCLES  (CONV_CYCLES),
  .SCK_DIV      (SCK_DIV),
  .PERIOD_CYCLES(PERIOD_CYCLES)
) i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .cnv        (cnv),
  .sck        (sck),
  .resultValid(resultValid)
);

// File: tb/test_sar_readout_ctrl.sv
`timescale 1ns/1ps
module test_sar_readout_ctrl;

  localparam int DW    = 18;
  localparam int CONV  = 160;
  localparam int DIV   = 2;
  localparam int PER   = 250;
  localparam int NEED  = CONV + 2 * DIV * DW + 3;
  localparam int PEFF  = (PER > NEED) ? PER : NEED;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic          freeRun = 1'b0;
  logic          sdo = 1'b0;
  logic          cnv;
  logic          sck;
  logic [DW-1:0] result;
  logic          resultValid;

  int     checks = 0;
  int     fails = 0;
  bit     done = 1'b0;
  longint cyc = 0;

  sar_readout_ctrl #(
    .DATA_W(DW), .CONV_CYCLES(CONV), .SCK_DIV(DIV), .PERIOD_CYCLES(PER)
  ) i_sar_readout_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .freeRun(freeRun),
    .cnv(cnv), .sck(sck), .sdo(sdo), .result(result), .resultValid(resultValid)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Converter model and monitor, both on the falling system clock edge.
  logic          cnvPrev, sckPrev, validPrev, slaveActive;
  int            cnvLen, sckHighLen, fallCnt, slaveIdx, frStreak;
  int            rises = 0, valids = 0;
  longint        lastRise;
  bit            haveRise;
  logic [DW-1:0] word;

  always @(negedge clk) begin
    if (!rstN) begin
      cnvPrev <= 1'b0; sckPrev <= 1'b0; validPrev <= 1'b0; slaveActive <= 1'b0;
      cnvLen <= 0; sckHighLen <= 0; fallCnt <= 0; slaveIdx <= 0; frStreak <= 0;
      haveRise <= 1'b0; sdo <= 1'b0;
    end else begin
      if (!freeRun) frStreak <= 0;
      if (cnv && !cnvPrev) begin
        if (haveRise) begin
          check(cyc - lastRise >= PEFF, "R7", "rise spacing", cyc - lastRise, PEFF);
          if (freeRun && frStreak > 0)
            check(cyc - lastRise == PEFF, "R9", "free-run spacing", cyc - lastRise, PEFF);
        end
        haveRise <= 1'b1; lastRise <= cyc; rises <= rises + 1;
        word <= DW'($urandom()); fallCnt <= 0; cnvLen <= 1;
        frStreak <= freeRun ? frStreak + 1 : 0;
      end else if (cnv) begin
        cnvLen <= cnvLen + 1;
      end
      if (!cnv && cnvPrev) begin
        check(cnvLen == CONV, "R3", "cnv high length", cnvLen, CONV);
        sdo <= word[DW-1]; slaveIdx <= 1; slaveActive <= 1'b1;
      end
      if (sck && !sckPrev) begin
        check(!cnv, "R4", "sck rose with cnv high", cnv, 0);
        sckHighLen <= 1;
      end else if (sck) begin
        sckHighLen <= sckHighLen + 1;
      end
      if (!sck && sckPrev) begin
        check(sckHighLen == DIV, "R4", "sck high length", sckHighLen, DIV);
        fallCnt <= fallCnt + 1;
        if (slaveActive) begin
          if (slaveIdx == DW) begin
            slaveActive <= 1'b0; sdo <= 1'($urandom());
          end else begin
            sdo <= word[DW-1-slaveIdx]; slaveIdx <= slaveIdx + 1;
          end
        end
      end
      if (resultValid) begin
        check(!validPrev, "R6", "valid wider than one cycle", 1, 0);
        if (!validPrev) begin
          check(result == word, "R5", "assembled word", result, word);
          check(fallCnt == DW, "R4", "falling sck edges", fallCnt, DW);
          check(!cnv, "R6", "cnv level at valid", cnv, 0);
          valids <= valids + 1;
        end
      end
      cnvPrev <= cnv; sckPrev <= sck; validPrev <= resultValid;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseStart();
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    int r0;
    int v0;
    void'($urandom(32'd2024));
    idle(5);
    check({cnv, sck, resultValid} == 3'b000, "R1", "outputs in reset", {cnv, sck, resultValid}, 0);
    rstN = 1'b1;
    idle(1);
    check({cnv, sck, resultValid} == 3'b000, "R1", "outputs after release", {cnv, sck, resultValid}, 0);

    // R2: no request, no cycle
    r0 = rises;
    idle(300);
    check(rises == r0, "R2", "rises without request", rises - r0, 0);

    // R2: one request, one conversion
    pulseStart();
    idle(PEFF + 20);
    check(rises == 1, "R2", "rises after one request", rises, 1);
    check(valids == 1, "R6", "results after one request", valids, 1);

    // R8: burst of requests during a running cycle
    r0 = rises;
    pulseStart();
    idle(20); pulseStart();
    idle(10); pulseStart();
    idle(3 * PEFF);
    check(rises - r0 == 2, "R8", "conversions from burst", rises - r0, 2);

    // Random request gaps, many landing inside a running cycle
    for (int i = 0; i < 40; i++) begin
      idle($urandom_range(0, 400));
      pulseStart();
    end
    idle(2 * PEFF);
    check(valids == rises, "R6", "results versus conversions", valids, rises);
    r0 = rises;
    idle(400);
    check(rises == r0, "R2", "rises after requests drained", rises - r0, 0);

    // R9: free-run
    @(negedge clk) freeRun = 1'b1;
    r0 = rises;
    idle(8 * PEFF - 1);
    freeRun = 1'b0;
    idle(2 * PEFF);
    check(rises - r0 == 8, "R9", "free-run conversions", rises - r0, 8);

    // R1: reset inside a conversion
    v0 = valids;
    pulseStart();
    idle(50);
    rstN = 1'b0;
    idle(2);
    check({cnv, sck, resultValid} == 3'b000, "R1", "outputs on mid-cycle reset", {cnv, sck, resultValid}, 0);
    rstN = 1'b1;
    idle(2 * PEFF);
    check(valids == v0, "R1", "results from aborted cycle", valids - v0, 0);
    pulseStart();
    idle(PEFF + 20);
    check(valids == v0 + 1, "R5", "result after recovery", valids - v0, 1);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule